// File: doc/BRIEF.md
# Dual-Result Three-Operand Hash Helper

A small memory-mapped helper for software hash rounds. It holds three 32-bit operand registers. From them it always computes two results side by side. The first is the wrapping sum of all three operands. The second is the exclusive-or of the first two operands, rotated right by a variable amount taken from the third operand.

Software writes operands at fixed offsets and then reads back the result it needs. Because both results exist at all times, there is no operation-select register and no compute-side mode mux. The only selection is the read mux, which is driven by the read offset. An optional register stage after the two datapaths shortens the critical path for a slow fabric clock. It adds one cycle of latency.

Top module: `dual_result_hash_helper`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), every operand offset and both result offsets read as zero.
- R2: A write with wr_en high at offset 0, 1 or 2 stores wr_data into the first, second or third operand. Reading the same offset after that clock edge returns the stored word.
- R3: Reading offset 4 returns the sum of the three operands modulo 2^32.
- R4: Reading offset 5 returns the first operand xor the second operand, rotated right by the value of bits [4:0] of the third operand.
- R5: Bits [31:5] of the third operand do not change the rotated result, but they do take part in the sum.
- R6: When bits [4:0] of the third operand are zero, offset 5 returns the xor of the first two operands unchanged.
- R7: With REG_RESULTS=1, both results reflect an operand write from the second clock edge after the write is presented. After only the first edge, they still show the previous values. With REG_RESULTS=0, they reflect the write after the first edge.
- R8: Writes to offsets 3, 4, 5, 6 and 7 change no operand and no result.
- R9: Reads of the unmapped offsets 3, 6 and 7 return zero.
- R10: Both results are derived from one operand set at the same time. Reading offset 4 and then offset 5, with no write in between, gives the sum and the rotation of identical operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 3 | Write offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read offset (combinational read) |
| rd_data | output | 32 | Read data for rd_addr |

## Verification
The hardest case to bring about is the one-cycle window in which the new operands are already stored but the registered results still hold the old values. The stimulus writes an operand and reads the sum immediately after the first edge, expecting the old value. It then reads again one edge later, expecting the new value. The rotate path is driven with amounts of 0, 31 and single set bits in the amount field, and with a third operand whose upper bits are set. This separates the rotate amount from the full operand and shows that the upper bits reach the sum but not the rotation.

// File: rtl/hx_pkg.sv
package hx_pkg;
    localparam int WORD_W  = 32;
    localparam int ROT_W   = $clog2(WORD_W);
    localparam int ADDR_W  = 3;
    localparam int NUM_OPS = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ROT_W-1:0]  rot_amt_t;
    typedef logic [ADDR_W-1:0] offs_t;

    typedef enum logic [ADDR_W-1:0] {
        OFF_OPA = 3'd0,
        OFF_OPB = 3'd1,
        OFF_OPC = 3'd2,
        OFF_SUM = 3'd4,
        OFF_ROT = 3'd5
    } reg_off_e;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
    } operands_t;

    typedef struct packed {
        word_t sum;
        word_t rot;
    } results_t;

    function automatic rot_amt_t amt_of(input word_t c);
        return c[ROT_W-1:0];
    endfunction
endpackage

// File: rtl/hx_operand_bank.sv
module hx_operand_bank
    import hx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  offs_t     wr_addr,
    input  word_t     wr_data,
    output operands_t ops
);
    word_t op_r [NUM_OPS];

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        always_ff @(posedge clk) begin
            if (rst) begin
                op_r[i] <= '0;
            end else if (wr_en && (wr_addr == offs_t'(i))) begin
                op_r[i] <= wr_data;
            end
        end
    end

    assign ops.a = op_r[0];
    assign ops.b = op_r[1];
    assign ops.c = op_r[2];
endmodule

// File: rtl/hx_sum3.sv
module hx_sum3
    import hx_pkg::*;
(
    input  operands_t ops,
    output word_t     sum
);
    word_t partial;

    always_comb begin
        partial = ops.a + ops.b;
        sum     = partial + ops.c;
    end
endmodule

// File: rtl/hx_xor_rotr.sv
module hx_xor_rotr
    import hx_pkg::*;
(
    input  word_t    x,
    input  word_t    y,
    input  rot_amt_t amt,
    output word_t    z
);
    word_t stg [ROT_W+1];

    assign stg[0] = x ^ y;

    for (genvar s = 0; s < ROT_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stg[s+1] = amt[s] ? {stg[s][SH-1:0], stg[s][WORD_W-1:SH]}
                                 : stg[s];
    end

    assign z = stg[ROT_W];
endmodule

// File: rtl/hx_result_stage.sv
module hx_result_stage
    import hx_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  results_t res_d,
    output results_t res_q
);
    if (REGISTERED) begin : g_reg
        results_t r;
        always_ff @(posedge clk) begin
            if (rst) r <= '0;
            else     r <= res_d;
        end
        assign res_q = r;
    end else begin : g_pass
        logic unused_clk;
        assign unused_clk = clk ^ rst;
        assign res_q = res_d;
    end
endmodule

// File: rtl/hx_read_mux.sv
module hx_read_mux
    import hx_pkg::*;
(
    input  offs_t     rd_addr,
    input  operands_t ops,
    input  results_t  res,
    output word_t     rd_data
);
    always_comb begin
        case (reg_off_e'(rd_addr))
            OFF_OPA: rd_data = ops.a;
            OFF_OPB: rd_data = ops.b;
            OFF_OPC: rd_data = ops.c;
            OFF_SUM: rd_data = res.sum;
            OFF_ROT: rd_data = res.rot;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dual_result_hash_helper.sv
module dual_result_hash_helper
    import hx_pkg::*;
#(
    parameter bit REG_RESULTS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    operands_t ops_q;
    results_t  res_d;
    results_t  res_q;

    hx_operand_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ops     (ops_q)
    );

    hx_sum3 u_sum (
        .ops (ops_q),
        .sum (res_d.sum)
    );

    hx_xor_rotr u_rot (
        .x   (ops_q.a),
        .y   (ops_q.b),
        .amt (amt_of(ops_q.c)),
        .z   (res_d.rot)
    );

    hx_result_stage #(.REGISTERED(REG_RESULTS)) u_stage (
        .clk   (clk),
        .rst   (rst),
        .res_d (res_d),
        .res_q (res_q)
    );

    hx_read_mux u_mux (
        .rd_addr (rd_addr),
        .ops     (ops_q),
        .res     (res_q),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/hx_helper_chk.sv
module hx_helper_chk
    import hx_pkg::*;
#(
    parameter bit REG_RESULTS = 1'b1
) (
    input logic      clk,
    input logic      rst,
    input logic      wr_en,
    input offs_t     wr_addr,
    input word_t     wr_data,
    input offs_t     rd_addr,
    input word_t     rd_data,
    input operands_t ops_q
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    function automatic word_t ref_rot(input word_t a, input word_t b, input rot_amt_t k);
        word_t x;
        x = a ^ b;
        return (x >> k) | (x << (WORD_W - int'(k)));
    endfunction

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (ops_q == '0)); // R1

    AST_OPA_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd0) |=> (ops_q.a == $past(wr_data))); // R2

    AST_OPC_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd2) |=> (ops_q.c == $past(wr_data))); // R2

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (seen && wr_en && wr_addr >= 3'd3) |=> (ops_q == $past(ops_q))); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 3'd3 || rd_addr == 3'd6 || rd_addr == 3'd7) |-> (rd_data == '0)); // R9

    if (REG_RESULTS) begin : g_reg
        AST_SUM_READ: assert property (@(posedge clk) disable iff (rst)
            (seen && rd_addr == 3'd4) |->
            (rd_data == word_t'($past(ops_q.a) + $past(ops_q.b) + $past(ops_q.c)))); // R3

        AST_ROT_READ: assert property (@(posedge clk) disable iff (rst)
            (seen && rd_addr == 3'd5) |->
            (rd_data == ref_rot($past(ops_q.a), $past(ops_q.b), $past(ops_q.c[ROT_W-1:0])))); // R4
    end else begin : g_comb
        AST_SUM_READ: assert property (@(posedge clk) disable iff (rst)
            (rd_addr == 3'd4) |-> (rd_data == word_t'(ops_q.a + ops_q.b + ops_q.c))); // R3

        AST_ROT_READ: assert property (@(posedge clk) disable iff (rst)
            (rd_addr == 3'd5) |-> (rd_data == ref_rot(ops_q.a, ops_q.b, ops_q.c[ROT_W-1:0]))); // R4
    end
endmodule

bind dual_result_hash_helper hx_helper_chk #(.REG_RESULTS(REG_RESULTS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ops_q   (ops_q)
);

// File: tb/dual_result_hash_helper_tb_top.sv
module dual_result_hash_helper_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    localparam logic [95:0] VECS [NVEC] = '{
        {32'h00000001, 32'h00000002, 32'h00000003},
        {32'hFFFFFFFF, 32'h00000001, 32'h00000000},
        {32'h12345678, 32'h9ABCDEF0, 32'h0000001F},
        {32'hDEADBEEF, 32'h01234567, 32'h00000010},
        {32'h80000000, 32'h80000000, 32'hFFFFFFE8},
        {32'hA5A5A5A5, 32'h0F0F0F0F, 32'h12345607}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] cur_a, cur_b, cur_c;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_result_hash_helper dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    function automatic logic [31:0] exp_sum(input logic [31:0] a, b, c);
        return a + b + c;
    endfunction

    function automatic logic [31:0] exp_rot(input logic [31:0] a, b, c);
        logic [31:0] x;
        int k;
        x = a ^ b;
        k = int'(c[4:0]);
        return (x >> k) | (x << (32 - k));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_check(input logic [2:0] addr, input string req, input logic [31:0] exp);
        rd_addr = addr;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic wr(input logic [2:0] addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [31:0] a, b, c);
        wr(3'd0, a); wr(3'd1, b); wr(3'd2, c);
        cur_a = a; cur_b = b; cur_c = c;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 8; i++) rd_check(3'(i), "R1", 32'h0);

        // Table walk: R2, R3, R4, R10
        for (int v = 0; v < NVEC; v++) begin
            load(VECS[v][95:64], VECS[v][63:32], VECS[v][31:0]);
            rd_check(3'd4, "R3", exp_sum(cur_a, cur_b, cur_c));
            rd_check(3'd5, "R4_R10", exp_rot(cur_a, cur_b, cur_c));
            rd_check(3'd0, "R2", cur_a);
            rd_check(3'd1, "R2", cur_b);
            rd_check(3'd2, "R2", cur_c);
        end

        // R6: zero rotate gives plain xor
        load(32'hCAFEF00D, 32'h0BADBEEF, 32'h00000000);
        rd_check(3'd5, "R6", 32'hCAFEF00D ^ 32'h0BADBEEF);

        // R5: upper bits of third operand reach sum only
        load(32'h01020304, 32'h10203040, 32'h00000005);
        rd_check(3'd5, "R5", exp_rot(cur_a, cur_b, 32'h5));
        rd_check(3'd4, "R5", 32'h01020304 + 32'h10203040 + 32'h5);
        wr(3'd2, 32'hFFFFFF05);
        @(negedge clk);
        rd_check(3'd5, "R5", exp_rot(cur_a, cur_b, 32'h5));
        rd_check(3'd4, "R5", 32'h01020304 + 32'h10203040 + 32'hFFFFFF05);
        cur_c = 32'hFFFFFF05;

        // R7: exact result latency with registered results
        wr(3'd0, 32'h00001000);
        rd_check(3'd0, "R7", 32'h00001000);
        rd_check(3'd4, "R7", exp_sum(cur_a, cur_b, cur_c));
        rd_check(3'd5, "R7", exp_rot(cur_a, cur_b, cur_c));
        cur_a = 32'h00001000;
        @(negedge clk);
        rd_check(3'd4, "R7", exp_sum(cur_a, cur_b, cur_c));
        rd_check(3'd5, "R7", exp_rot(cur_a, cur_b, cur_c));

        // R8: writes to non-operand offsets are ignored
        for (int o = 3; o < 8; o++) wr(3'(o), 32'h5A5A5A5A);
        @(negedge clk);
        rd_check(3'd0, "R8", cur_a);
        rd_check(3'd1, "R8", cur_b);
        rd_check(3'd2, "R8", cur_c);
        rd_check(3'd4, "R8", exp_sum(cur_a, cur_b, cur_c));
        rd_check(3'd5, "R8", exp_rot(cur_a, cur_b, cur_c));

        // R9: unmapped reads return zero with nonzero operands
        rd_check(3'd3, "R9", 32'h0);
        rd_check(3'd6, "R9", 32'h0);
        rd_check(3'd7, "R9", 32'h0);

        // R1: reset again clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_check(3'd0, "R1", 32'h0);
        rd_check(3'd2, "R1", 32'h0);
        rd_check(3'd4, "R1", 32'h0);
        rd_check(3'd5, "R1", 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule